// File: doc/BRIEF.md
# Victim and Next-Victim Replacement Tracker

This block keeps the replacement state of an N-way set-associative cache, one small record per set. Each record names two ways. The victim is the way to evict on the next miss. The next victim is the way that takes over when the victim leaves its role. All remaining ways count as ordinary and carry no per-way state.

The cache controller presents one event per clock cycle: a set index, a miss-or-hit flag and, for hits, the way that hit. A miss evicts the current victim, and that way then becomes ordinary. The next victim moves up to victim. A fresh next victim is then drawn from the ordinary ways by a free-running pseudo-random generator inside the block. Hits change the record only when they land on one of the two tracked ways.

The victim output is a combinational read of the addressed set's record, so it always shows the state from before the current cycle's update. Tag compare, data storage and refill are handled elsewhere.

Top module: `vnv_repl_tracker`

## Requirements
- R1: A synchronous active-high reset sets every set's victim to way 0 and its next victim to way 1.
- R2: `victim_way` shows the victim of the set on `evt_set` from before the current cycle's update. An event changes it only after the next rising clock edge.
- R3: A miss (`evt_valid`=1, `evt_hit`=0, `evt_way` ignored) makes the former next victim the new victim.
- R4: After a miss, the new next victim differs from the new victim and from the way just replaced (the old victim).
- R5: A hit (`evt_hit`=1) whose `evt_way` equals the victim promotes the next victim to victim. The new next victim differs from both the new victim and the old victim.
- R6: A hit on the next-victim way leaves the victim unchanged. The new next victim differs from the victim and from the way that was hit.
- R7: A hit on an ordinary way changes neither the victim nor the next victim.
- R8: In every set the victim and next victim always name different ways.
- R9: An event changes the record of the addressed set only.
- R10: The next-victim choice varies, so repeated misses to one set eventually make every way the victim.
- R11: With `evt_valid`=0 no record changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_hit | input | 1 | 1 = hit on `evt_way`, 0 = miss |
| evt_set | input | SET_W | Set index of the event or lookup |
| evt_way | input | WAY_W | Way that hit (ignored on a miss) |
| victim_way | output | WAY_W | Current victim of set `evt_set` |

## Verification
Because the next-victim choice is random, the bench cannot predict it exactly. It tracks each set's victim exactly. For the next victim it keeps either an exact value or a mask of the ways it is known to avoid, and it checks every promotion against that knowledge. Misses and hits on the victim show whether promotion and exclusion work. Hits on other ways tell a hit on the next victim (the victim stays put and the next victim moves) apart from a hit on an ordinary way (nothing moves). Idle cycles and lookups of untouched sets show that no record changes by accident. A long run of misses to one set shows whether the random choice really spreads across the ways.

// File: rtl/vnv_pkg.sv
package vnv_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_MISS,
    EV_HIT_V,
    EV_HIT_NV,
    EV_HIT_O
  } evt_kind_e;
endpackage

// File: rtl/vnv_lfsr.sv
module vnv_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] rnd
);
  always_ff @(posedge clk) begin
    if (rst) rnd <= SEED;
    else     rnd <= {1'b0, rnd[W-1:1]} ^ (rnd[0] ? TAPS : '0);
  end
endmodule

// File: rtl/vnv_update.sv
module vnv_update import vnv_pkg::*; #(
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             evt_valid,
  input  logic             evt_hit,
  input  logic [WAY_W-1:0] evt_way,
  input  logic [WAY_W-1:0] cur_v,
  input  logic [WAY_W-1:0] cur_nv,
  output evt_kind_e        kind,
  output logic [WAY_W-1:0] keep_way,
  output logic [WAY_W-1:0] drop_way
);
  always_comb begin
    kind     = EV_NONE;
    keep_way = cur_v;
    drop_way = cur_nv;
    if (evt_valid) begin
      if (!evt_hit) begin
        kind     = EV_MISS;
        keep_way = cur_nv;
        drop_way = cur_v;
      end else if (evt_way == cur_v) begin
        kind     = EV_HIT_V;
        keep_way = cur_nv;
        drop_way = cur_v;
      end else if (evt_way == cur_nv) begin
        kind     = EV_HIT_NV;
        keep_way = cur_v;
        drop_way = cur_nv;
      end else begin
        kind = EV_HIT_O;
      end
    end
  end
endmodule

// File: rtl/vnv_pick.sv
module vnv_pick #(
  parameter int WAYS  = 4,
  parameter int RW    = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int ELIG  = WAYS - 2
) (
  input  logic [RW-1:0]    rnd,
  input  logic [WAY_W-1:0] keep_way,
  input  logic [WAY_W-1:0] drop_way,
  output logic [WAY_W-1:0] pick_way
);
  int lo, hi, w;
  always_comb begin
    lo = (keep_way < drop_way) ? int'(keep_way) : int'(drop_way);
    hi = (keep_way < drop_way) ? int'(drop_way) : int'(keep_way);
    w  = int'(rnd % RW'(ELIG));
    if (w >= lo) w = w + 1;
    if (w >= hi) w = w + 1;
    pick_way = WAY_W'(w);
  end
endmodule

// File: rtl/vnv_repl_tracker.sv
module vnv_repl_tracker import vnv_pkg::*; #(
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int LFSR_W = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic             evt_hit,
  input  logic [SET_W-1:0] evt_set,
  input  logic [WAY_W-1:0] evt_way,
  output logic [WAY_W-1:0] victim_way
);
  logic [WAY_W-1:0]  v_q  [SETS];
  logic [WAY_W-1:0]  nv_q [SETS];
  logic [WAY_W-1:0]  rd_v, rd_nv, keep_way, drop_way, pick_way;
  logic [LFSR_W-1:0] rnd;
  evt_kind_e         kind;
  logic              upd_en;

  assign rd_v       = v_q[evt_set];
  assign rd_nv      = nv_q[evt_set];
  assign victim_way = rd_v;

  vnv_lfsr #(.W(LFSR_W)) u_lfsr (.clk(clk), .rst(rst), .rnd(rnd));

  vnv_update #(.WAYS(WAYS)) u_upd (
    .evt_valid(evt_valid), .evt_hit(evt_hit), .evt_way(evt_way),
    .cur_v(rd_v), .cur_nv(rd_nv),
    .kind(kind), .keep_way(keep_way), .drop_way(drop_way)
  );

  vnv_pick #(.WAYS(WAYS), .RW(LFSR_W)) u_pick (
    .rnd(rnd), .keep_way(keep_way), .drop_way(drop_way), .pick_way(pick_way)
  );

  assign upd_en = (kind == EV_MISS) || (kind == EV_HIT_V) || (kind == EV_HIT_NV);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s]  <= WAY_W'(0);
        nv_q[s] <= WAY_W'(1);
      end
    end else if (upd_en) begin
      v_q[evt_set]  <= keep_way;
      nv_q[evt_set] <= pick_way;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (v_q[0] == WAY_W'(0) && nv_q[0] == WAY_W'(1))); // R1
  AST_V_NE_NV: assert property (@(posedge clk) disable iff (rst)
    rd_v != rd_nv); // R8
  AST_MISS_PROMOTE: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_hit) |=> v_q[$past(evt_set)] == $past(rd_nv)); // R3
  AST_PICK_EXCLUDES: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> (pick_way != keep_way && pick_way != drop_way)); // R4
  AST_HIT_NV_KEEPS_V: assert property (@(posedge clk) disable iff (rst)
    (kind == EV_HIT_NV) |=> v_q[$past(evt_set)] == $past(rd_v)); // R6
  AST_HIT_O_STILL: assert property (@(posedge clk) disable iff (rst)
    (kind == EV_HIT_O) |=> (v_q[$past(evt_set)] == $past(rd_v) &&
                            nv_q[$past(evt_set)] == $past(rd_nv))); // R7
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (rst)
    !evt_valid |=> v_q[$past(evt_set)] == $past(rd_v)); // R11
endmodule

// File: tb/test_vnv_repl_tracker.sv
module test_vnv_repl_tracker;
  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int WW   = $clog2(WAYS);
  localparam int SW   = $clog2(SETS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev  = 1'b0;
  logic          eh  = 1'b0;
  logic [SW-1:0] es  = '0;
  logic [WW-1:0] ew  = '0;
  logic [WW-1:0] vw;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int            mv  [SETS];
  bit            nvk [SETS];
  int            nvv [SETS];
  bit [WAYS-1:0] ex  [SETS];

  always #5 clk = ~clk;

  vnv_repl_tracker #(.WAYS(WAYS), .SETS(SETS)) i_vnv_repl_tracker (
    .clk(clk), .rst(rst), .evt_valid(ev), .evt_hit(eh),
    .evt_set(es), .evt_way(ew), .victim_way(vw)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected promotion target: exact if known, otherwise outside the avoid mask
  function automatic bit promo_ok(int s, int w);
    return nvk[s] ? (w == nvv[s]) : !ex[s][w];
  endfunction

  function automatic int promo_exp(int s);
    return nvk[s] ? nvv[s] : int'(~ex[s]);
  endfunction

  task automatic evt(int s, bit val, bit h, int w);
    int old_v;
    int nv_w;
    old_v = mv[s];
    es = SW'(s); ev = val; eh = h; ew = WW'(w);
    #1;
    chk(int'(vw) == old_v, "R2 pre-edge victim", int'(vw), old_v);
    @(negedge clk);
    ev = 1'b0;
    #1;
    nv_w = int'(vw);
    if (!val) begin
      chk(nv_w == old_v, "R11 R9 idle no change", nv_w, old_v);
    end else if (!h || w == old_v) begin
      chk(promo_ok(s, nv_w), h ? "R5 R8 promote" : "R3 R4 R8 promote", nv_w, promo_exp(s));
      chk(nv_w != old_v, "R8 victim moved", nv_w, old_v);
      mv[s]  = nv_w;
      nvk[s] = 0;
      ex[s]  = WAYS'((1 << nv_w) | (1 << old_v));
    end else begin
      chk(nv_w == old_v, "R6 R7 victim kept", nv_w, old_v);
      if (!(nvk[s] && w != nvv[s])) begin
        nvk[s] = 0;
        ex[s]  = WAYS'((1 << old_v) | (1 << w));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    bit [WAYS-1:0] seen;
    void'($urandom(32'd1234));
    for (int s = 0; s < SETS; s++) begin
      mv[s] = 0; nvk[s] = 1; nvv[s] = 1; ex[s] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: every set starts with victim 0
    for (int s = 0; s < SETS; s++) begin
      es = SW'(s); #1;
      chk(vw == WW'(0), "R1 reset victim", int'(vw), 0);
    end
    @(negedge clk);
    // R7 then R3: ordinary hit keeps state, miss promotes known next victim (1)
    evt(2, 1, 1, 3);
    evt(2, 1, 0, 0);
    chk(mv[2] == 1, "R3 miss after reset", mv[2], 1);
    // R5: hit on victim promotes way 1
    evt(5, 1, 1, 0);
    chk(mv[5] == 1, "R5 hit victim", mv[5], 1);
    // R6: hit on next victim keeps victim, new next victim avoids 0 and 1
    evt(6, 1, 1, 1);
    evt(6, 1, 0, 0);
    // R9: sets untouched so far still hold victim 0
    evt(7, 0, 0, 0);
    evt(4, 0, 0, 0);
    // R10: repeated misses visit every way
    seen = '0;
    for (int i = 0; i < 60; i++) begin
      evt(9, 1, 0, 0);
      seen[mv[9]] = 1'b1;
    end
    chk(seen == '1, "R10 all ways become victim", int'(seen), (1 << WAYS) - 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int s, r, w;
      s = $urandom_range(0, SETS - 1);
      r = $urandom_range(0, 3);
      w = $urandom_range(0, WAYS - 1);
      case (r)
        0: evt(s, 0, 0, 0);
        1: evt(s, 1, 0, w);
        2: evt(s, 1, 1, mv[s]);
        default: begin
          if (w == mv[s]) w = (w + 1) % WAYS;
          evt(s, 1, 1, w);
        end
      endcase
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule